// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol side of a byte-addressed serial memory of 4096 bytes that sits behind a two-wire bus (SCL clock, SDA data). A fast system clock oversamples both wires. The block finds Start and Stop conditions and decodes the select byte. It takes in a two-byte word address, then either forwards incoming data bytes to a page-write engine or fetches bytes from a synchronous read port and shifts them out. SDA is driven only as an open-drain pull-down enable.

One address pointer is kept across transactions. A bus master can therefore read from where the last access ended, load a new address with a write-mode header and a repeated Start, or stream bytes with its own acknowledges. Two type codes are accepted: one selects the main array and one selects a separate 32-byte identification page.

While the page-write engine reports a write cycle in progress, the select byte gets no acknowledge. The master uses this to poll for completion.

Top module: `eep_slave_ctrl`

## Requirements
- R1: A Start (SDA falling while SCL high) at any point ends the current command and begins a new select byte. A Stop (SDA rising while SCL high) returns to idle. SDA changes while SCL is high never count as data bits.
- R2: Bits are MSB first. The select byte is type[7:4], pins[3:1], rd[0]. It is accepted only when the type is 1010 or 1011 and bits 3..1 equal `dev_pins`. Otherwise the block gives no acknowledge and keeps `sda_oe` low until the next Start.
- R3: Each received byte that is accepted (select, both address bytes, write data) is acknowledged by `sda_oe`=1 during the ninth SCL high phase.
- R4: The word address is two bytes, high byte first. Only the low 12 bits form the address, and bits 15..12 have no effect.
- R5: A random read (write-mode select, word address, repeated Start, read-mode select) returns the byte stored at the loaded address.
- R6: A read with no address phase returns the byte after the last one accessed. After address 4095 it continues at address 0.
- R7: In a read, each master acknowledge (SDA low on the ninth clock) causes the next byte to be sent from the incremented address, wrapping from 4095 to 0. A master NoAck (SDA high) ends the transfer, and `sda_oe` stays low until the next Start.
- R8: Each write data byte produces a one-cycle `wr_valid` carrying the address and data. Within a write, only the low 5 address bits advance, so the address wraps inside its 32-byte page.
- R9: A Stop after at least one write data byte gives a one-cycle `wr_commit`. A Start that cuts off such a write gives a one-cycle `wr_drop` and no commit.
- R10: While `wr_busy` is 1 the select byte is not acknowledged. Once it is 0 again, the select byte is acknowledged.
- R11: Type 1011 routes accesses to the identification page: `wr_id`=1 on its writes and `mem_id`=1 on its reads. Type 1010 leaves both at 0.
- R12: After reset `sda_oe`, `wr_valid`, `wr_commit` and `wr_drop` are 0 and the pointer is 0.
- R13: Read data bits change only after SCL falls. `sda_oe`=1 means the bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level (wired-AND) |
| dev_pins | input | 3 | Strapped device address |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_rd_en | output | 1 | Read strobe, data due next cycle |
| mem_id | output | 1 | Read targets identification page |
| mem_addr | output | 12 | Read address |
| mem_rd_data | input | 8 | Read data, one cycle after strobe |
| wr_busy | input | 1 | Write engine cycle in progress |
| wr_valid | output | 1 | One write byte presented |
| wr_id | output | 1 | Write targets identification page |
| wr_addr | output | 12 | Write byte address |
| wr_data | output | 8 | Write byte data |
| wr_commit | output | 1 | Buffered page may be programmed |
| wr_drop | output | 1 | Buffered page must be discarded |

## Verification
The bench aims at the pointer boundaries. It checks the wrap from 4095 to 0 in a streamed read and in a following header-less read; a design that saturated or carried into bit 12 would return the wrong bytes. It checks a page write that starts two bytes before a page end, where a full-width increment would spill into the next page. The bench also checks a write cut by a repeated Start, which must be dropped, not committed. It checks a polled select during the write cycle, which a design ignoring `wr_busy` would acknowledge. It checks a select with wrong pins or wrong type, where any pull-down on later clocks would corrupt other traffic. Finally, it clocks on after a master NoAck, where a design that kept streaming would drive data bits.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 5;
    localparam int SYNC_STAGES = 2;

    localparam logic [3:0] KIND_ARRAY = 4'b1010;
    localparam logic [3:0] KIND_IDPG  = 4'b1011;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SELECT,
        PH_WADR_HI,
        PH_WADR_LO,
        PH_WDATA,
        PH_RDATA,
        PH_MUTE
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic [3:0] kind;
        logic [2:0] pins;
        logic       rd;
    } select_t;

    function automatic select_t split_select(input logic [7:0] b);
        return select_t'(b);
    endfunction

    function automatic logic kind_known(input logic [3:0] k);
        return (k == KIND_ARRAY) || (k == KIND_IDPG);
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = eep_pkg::SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output eep_pkg::bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now_q;
    logic [LINES-1:0] last_q;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign now_q[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '1;
        else     last_q <= now_q;
    end

    always_comb begin
        ev.scl      = now_q[1];
        ev.sda      = now_q[0];
        ev.scl_rise = now_q[1] & ~last_q[1];
        ev.scl_fall = ~now_q[1] & last_q[1];
        ev.start    = now_q[1] & last_q[1] & last_q[0] & ~now_q[0];
        ev.stop     = now_q[1] & last_q[1] & ~last_q[0] & now_q[0];
    end

endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int ADDR_W = eep_pkg::ADDR_W,
    parameter int PAGE_W = eep_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_seq,
    input  logic              step_page,
    output logic [ADDR_W-1:0] ptr
);
    logic [PAGE_W-1:0] col_next;

    assign col_next = ptr[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)            ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_seq)  ptr <= ptr + 1'b1;
        else if (step_page) ptr <= {ptr[ADDR_W-1:PAGE_W], col_next};
    end

    AST_PAGE_STAY: assert property (@(posedge clk) disable iff (rst)
        step_page && !load |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R8

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        step_seq && !load && (&ptr) |=> ptr == '0); // R6

endmodule

// File: rtl/eep_link_fsm.sv
module eep_link_fsm
    import eep_pkg::*;
#(
    parameter int ADDR_W = eep_pkg::ADDR_W,
    parameter int DATA_W = eep_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        dev_pins,
    input  logic              wr_busy,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_val,
    output logic              ctr_step_seq,
    output logic              ctr_step_page,
    output logic              mem_rd_en,
    output logic              mem_id,
    output logic              sda_oe,
    output logic              wr_valid,
    output logic              wr_id,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              wr_drop
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);

    phase_t            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] shreg;
    logic [DATA_W-1:0] tx;
    logic [HI_W-1:0]   adr_hi;
    logic              own_ack;
    logic              got_data;
    logic              id_mode;
    logic              fetch_pend;

    logic [DATA_W-1:0] byte_in;
    logic              byte_done;
    logic              sel_ok;
    logic              mst_ack;
    select_t           sel;

    assign byte_in = {shreg, ev.sda};
    assign sel     = split_select(byte_in);
    assign sel_ok  = kind_known(sel.kind) && (sel.pins == dev_pins) && !wr_busy;

    assign byte_done = ev.scl_rise && (bit_cnt == LAST_BIT) &&
                       (phase inside {PH_SELECT, PH_WADR_HI, PH_WADR_LO, PH_WDATA});
    assign mst_ack   = ev.scl_rise && (bit_cnt == ACK_SLOT) && (phase == PH_RDATA) &&
                       !own_ack && !ev.sda;

    always_comb begin
        ctr_load      = byte_done && (phase == PH_WADR_LO);
        ctr_val       = {adr_hi, byte_in};
        ctr_step_page = byte_done && (phase == PH_WDATA);
        mem_rd_en     = (byte_done && (phase == PH_SELECT) && sel_ok && sel.rd) || mst_ack;
        ctr_step_seq  = mem_rd_en;
        mem_id        = (phase == PH_SELECT) ? (sel.kind == KIND_IDPG) : id_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            tx         <= '0;
            adr_hi     <= '0;
            own_ack    <= 1'b0;
            got_data   <= 1'b0;
            id_mode    <= 1'b0;
            fetch_pend <= 1'b0;
            sda_oe     <= 1'b0;
            wr_valid   <= 1'b0;
            wr_id      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_commit  <= 1'b0;
            wr_drop    <= 1'b0;
        end else begin
            wr_valid   <= 1'b0;
            wr_commit  <= 1'b0;
            wr_drop    <= 1'b0;
            fetch_pend <= mem_rd_en;
            if (fetch_pend) tx <= rd_data;

            if (ev.start) begin
                if (phase == PH_WDATA && got_data) wr_drop <= 1'b1;
                phase    <= PH_SELECT;
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                own_ack  <= 1'b0;
                got_data <= 1'b0;
            end else if (ev.stop) begin
                if (phase == PH_WDATA && got_data) wr_commit <= 1'b1;
                phase    <= PH_IDLE;
                bit_cnt  <= '0;
                sda_oe   <= 1'b0;
                own_ack  <= 1'b0;
                got_data <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.scl_rise) begin
                    if (bit_cnt == ACK_SLOT) begin
                        bit_cnt <= '0;
                        own_ack <= 1'b0;
                        if (phase == PH_RDATA && !own_ack && ev.sda) phase <= PH_MUTE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= byte_in[DATA_W-2:0];
                        if (byte_done) begin
                            own_ack <= 1'b1;
                            unique case (phase)
                                PH_SELECT: begin
                                    if (sel_ok) begin
                                        id_mode <= (sel.kind == KIND_IDPG);
                                        phase   <= sel.rd ? PH_RDATA : PH_WADR_HI;
                                    end else begin
                                        own_ack <= 1'b0;
                                        phase   <= PH_MUTE;
                                    end
                                end
                                PH_WADR_HI: begin
                                    adr_hi <= byte_in[HI_W-1:0];
                                    phase  <= PH_WADR_LO;
                                end
                                PH_WADR_LO: phase <= PH_WDATA;
                                PH_WDATA: begin
                                    wr_valid <= 1'b1;
                                    wr_data  <= byte_in;
                                    wr_addr  <= ptr;
                                    wr_id    <= id_mode;
                                    got_data <= 1'b1;
                                end
                                default: own_ack <= 1'b0;
                            endcase
                        end
                    end
                end else if (ev.scl_fall) begin
                    if (bit_cnt == ACK_SLOT)    sda_oe <= own_ack;
                    else if (phase == PH_RDATA) sda_oe <= ~tx[3'(LAST_BIT) - bit_cnt[2:0]];
                    else                        sda_oe <= 1'b0;
                end
            end
        end
    end

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_SELECT) && !sda_oe); // R1

    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MUTE) |-> !sda_oe); // R2

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R13

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, wr_commit, wr_drop})); // R9

    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_busy && $past(wr_busy) |-> !wr_valid); // R10

endmodule

// File: rtl/eep_slave_ctrl.sv
module eep_slave_ctrl #(
    parameter int ADDR_W = eep_pkg::ADDR_W,
    parameter int DATA_W = eep_pkg::DATA_W,
    parameter int PAGE_W = eep_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        dev_pins,
    output logic              sda_oe,
    output logic              mem_rd_en,
    output logic              mem_id,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              wr_busy,
    output logic              wr_valid,
    output logic              wr_id,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              wr_drop
);
    eep_pkg::bus_ev_t  ev;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ctr_val;
    logic              ctr_load;
    logic              ctr_step_seq;
    logic              ctr_step_page;

    eep_bus_sync #(.STAGES(eep_pkg::SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctr_load),
        .load_val  (ctr_val),
        .step_seq  (ctr_step_seq),
        .step_page (ctr_step_page),
        .ptr       (ptr)
    );

    eep_link_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .dev_pins      (dev_pins),
        .wr_busy       (wr_busy),
        .ptr           (ptr),
        .rd_data       (mem_rd_data),
        .ctr_load      (ctr_load),
        .ctr_val       (ctr_val),
        .ctr_step_seq  (ctr_step_seq),
        .ctr_step_page (ctr_step_page),
        .mem_rd_en     (mem_rd_en),
        .mem_id        (mem_id),
        .sda_oe        (sda_oe),
        .wr_valid      (wr_valid),
        .wr_id         (wr_id),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_commit     (wr_commit),
        .wr_drop       (wr_drop)
    );

    assign mem_addr = ptr;

endmodule

// File: tb/eep_slave_ctrl_tb.sv
module eep_slave_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CYC   = 300;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic [2:0]  dev_pins = 3'b101;
    logic        sda_oe, mem_rd_en, mem_id;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        wr_busy = 1'b0;
    logic        wr_valid, wr_id, wr_commit, wr_drop;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    int busy_cnt = 0;
    int commit_cnt = 0;
    int drop_cnt   = 0;

    logic [7:0]  ram   [0:4095];
    logic [7:0]  idram [0:31];
    logic [7:0]  mdl   [0:4095];
    logic [7:0]  mdl_id[0:31];
    logic [20:0] pend_q[$];
    logic [20:0] log_q[$];

    logic  mon_on  = 1'b0;
    logic  mon_exp = 1'b0;
    string mon_tag = "";

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_slave_ctrl u_dut (
        .clk (clk), .rst (rst), .scl_in (m_scl), .sda_in (sda_bus),
        .dev_pins (dev_pins), .sda_oe (sda_oe), .mem_rd_en (mem_rd_en),
        .mem_id (mem_id), .mem_addr (mem_addr), .mem_rd_data (mem_rd_data),
        .wr_busy (wr_busy), .wr_valid (wr_valid), .wr_id (wr_id),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_commit (wr_commit),
        .wr_drop (wr_drop)
    );

    // read port of the backing array
    always @(posedge clk)
        if (mem_rd_en) mem_rd_data <= mem_id ? idram[mem_addr[4:0]] : ram[mem_addr];

    // page-write engine stand-in
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_cnt != 0) busy_cnt--;
            if (wr_valid) begin
                pend_q.push_back({wr_id, wr_addr, wr_data});
                log_q.push_back({wr_id, wr_addr, wr_data});
            end
            if (wr_commit) begin
                foreach (pend_q[k]) begin
                    if (pend_q[k][20]) idram[pend_q[k][12:8]] = pend_q[k][7:0];
                    else               ram[pend_q[k][19:8]]   = pend_q[k][7:0];
                end
                pend_q.delete();
                busy_cnt = BUSY_CYC;
                commit_cnt++;
            end
            if (wr_drop) begin
                pend_q.delete();
                drop_cnt++;
            end
        end
        wr_busy = (busy_cnt != 0);
    end

    // per-clock comparison of the pull-down against the model expectation
    always @(negedge clk) begin
        if (mon_on) begin
            n_checks++;
            if (sda_oe !== mon_exp) begin
                n_err++;
                $display("FAIL %s: sda_oe=%0d expected %0d at %0t", mon_tag, sda_oe, mon_exp, $time);
            end
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_bit(input logic drv, input logic exp_oe, input string tag, output logic seen);
        m_sda = drv;
        tick(3);
        m_scl = 1'b1;
        tick(2);
        mon_exp = exp_oe; mon_tag = tag; mon_on = 1'b1;
        tick(4);
        seen = sda_bus;
        mon_on = 1'b0;
        tick(2);
        m_scl = 1'b0;
        tick(4);
    endtask

    task automatic do_start();
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(4);
        m_sda = 1'b0; tick(4);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(4);
        m_sda = 1'b1; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, tag, s);
        bus_bit(1'b1, exp_ack, tag, s);
        check_eq({tag, " ack"}, int'(!s), int'(exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic [7:0] got;
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, ~exp[i], tag, s);
            got[i] = s;
        end
        bus_bit(~mack, 1'b0, tag, s);
        check_eq({tag, " data"}, int'(got), int'(exp));
    endtask

    task automatic wait_ready();
        while (busy_cnt != 0) tick(1);
        tick(4);
    endtask

    task automatic random_read_hdr(input logic [7:0] wsel, input logic [15:0] a, input string tag);
        do_start();
        send_byte(wsel, 1'b1, tag);
        send_byte(a[15:8], 1'b1, tag);
        send_byte(a[7:0], 1'b1, tag);
        do_start();
        send_byte(wsel | 8'h01, 1'b1, tag);
    endtask

    task automatic check_log(input int idx, input int id, input int a, input int d, input string tag);
        if (log_q.size() <= idx) begin
            check_eq({tag, " log size"}, log_q.size(), idx + 1);
        end else begin
            check_eq({tag, " wr_id"},   int'(log_q[idx][20]),   id);
            check_eq({tag, " wr_addr"}, int'(log_q[idx][19:8]), a);
            check_eq({tag, " wr_data"}, int'(log_q[idx][7:0]),  d);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            ram[i] = 8'((i * 7 + 3) & 255);
            mdl[i] = ram[i];
        end
        for (int i = 0; i < 32; i++) begin
            idram[i]  = 8'(8'h40 + i);
            mdl_id[i] = idram[i];
        end
    end

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_err++;
        $display("FAIL watchdog: run did not finish, cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        tick(6);
        rst = 1'b0;
        tick(4);

        // R12: quiet after reset
        check_eq("R12 sda_oe", int'(sda_oe), 0);
        check_eq("R12 wr_valid", int'(wr_valid | wr_commit | wr_drop), 0);

        // R3 R8 R9: single byte write to 0x123
        log_q.delete();
        do_start();
        send_byte(8'hAA, 1'b1, "R3 select");
        send_byte(8'h01, 1'b1, "R3 addr hi");
        send_byte(8'h23, 1'b1, "R3 addr lo");
        send_byte(8'hA5, 1'b1, "R3 data");
        do_stop();
        tick(2);
        mdl[12'h123] = 8'hA5;
        check_log(0, 0, 12'h123, 8'hA5, "R8 byte write");
        check_eq("R9 commit count", commit_cnt, 1);

        // R10: polling during the write cycle
        do_start();
        send_byte(8'hAA, 1'b0, "R10 poll busy");
        do_stop();
        wait_ready();
        do_start();
        send_byte(8'hAA, 1'b1, "R10 poll ready");
        do_stop();
        tick(4);

        // R5: random read back
        random_read_hdr(8'hAA, 16'h0123, "R5 header");
        recv_byte(mdl[12'h123], 1'b0, "R5 R13 random read");
        do_stop();

        // R6: header-less read continues
        do_start();
        send_byte(8'hAB, 1'b1, "R6 select");
        recv_byte(mdl[12'h124], 1'b0, "R6 current read");
        do_stop();

        // R7: streamed read across the top of the array
        random_read_hdr(8'hAA, 16'h0FFE, "R7 header");
        recv_byte(mdl[12'hFFE], 1'b1, "R7 seq 0xFFE");
        recv_byte(mdl[12'hFFF], 1'b1, "R7 seq 0xFFF");
        recv_byte(mdl[12'h000], 1'b0, "R7 seq wrap 0x000");
        do_stop();
        do_start();
        send_byte(8'hAB, 1'b1, "R6 select after wrap");
        recv_byte(mdl[12'h001], 1'b0, "R6 current after wrap");
        do_stop();

        // R8: page write wraps inside its page
        log_q.delete();
        do_start();
        send_byte(8'hAA, 1'b1, "R8 select");
        send_byte(8'h00, 1'b1, "R8 addr hi");
        send_byte(8'h5E, 1'b1, "R8 addr lo");
        send_byte(8'h11, 1'b1, "R8 d0");
        send_byte(8'h22, 1'b1, "R8 d1");
        send_byte(8'h33, 1'b1, "R8 d2");
        send_byte(8'h44, 1'b1, "R8 d3");
        do_stop();
        tick(2);
        mdl[12'h05E] = 8'h11; mdl[12'h05F] = 8'h22;
        mdl[12'h040] = 8'h33; mdl[12'h041] = 8'h44;
        check_log(0, 0, 12'h05E, 8'h11, "R8 page 0");
        check_log(1, 0, 12'h05F, 8'h22, "R8 page 1");
        check_log(2, 0, 12'h040, 8'h33, "R8 page wrap 2");
        check_log(3, 0, 12'h041, 8'h44, "R8 page wrap 3");
        wait_ready();
        random_read_hdr(8'hAA, 16'h0040, "R8 readback header");
        recv_byte(mdl[12'h040], 1'b1, "R8 readback 0x040");
        recv_byte(mdl[12'h041], 1'b0, "R8 readback 0x041");
        do_stop();

        // R4: upper nibble of the word address has no effect
        random_read_hdr(8'hAA, 16'hF05E, "R4 header");
        recv_byte(mdl[12'h05E], 1'b0, "R4 upper bits ignored");
        do_stop();

        // R2: wrong pins, then wrong type: silent on every clock
        do_start();
        send_byte(8'hA0, 1'b0, "R2 wrong pins");
        send_byte(8'h00, 1'b0, "R2 muted byte");
        do_stop();
        do_start();
        send_byte(8'hCA, 1'b0, "R2 wrong type");
        send_byte(8'h55, 1'b0, "R2 muted byte 2");
        do_stop();

        // R1 R9: write cut off by a repeated Start is dropped
        log_q.delete();
        do_start();
        send_byte(8'hAA, 1'b1, "R1 select");
        send_byte(8'h00, 1'b1, "R1 addr hi");
        send_byte(8'h10, 1'b1, "R1 addr lo");
        send_byte(8'h99, 1'b1, "R1 data");
        do_start();
        do_stop();
        tick(2);
        check_eq("R9 drop count", drop_cnt, 1);
        check_eq("R9 no commit", commit_cnt, 2);
        check_eq("R1 not busy", int'(wr_busy), 0);
        random_read_hdr(8'hAA, 16'h0010, "R1 header");
        recv_byte(mdl[12'h010], 1'b0, "R1 aborted data not stored");
        do_stop();

        // R11: identification page write and read
        log_q.delete();
        do_start();
        send_byte(8'hBA, 1'b1, "R11 select");
        send_byte(8'h00, 1'b1, "R11 addr hi");
        send_byte(8'h05, 1'b1, "R11 addr lo");
        send_byte(8'h5A, 1'b1, "R11 data");
        do_stop();
        tick(2);
        mdl_id[5] = 8'h5A;
        check_log(0, 1, 12'h005, 8'h5A, "R11 id write");
        wait_ready();
        random_read_hdr(8'hBA, 16'h0005, "R11 id header");
        recv_byte(mdl_id[5], 1'b0, "R11 id read");
        do_stop();
        random_read_hdr(8'hAA, 16'h0005, "R11 array header");
        recv_byte(mdl[12'h005], 1'b0, "R11 array untouched");
        do_stop();

        // R7: after a NoAck the slave stays silent, pointer moved by one
        random_read_hdr(8'hAA, 16'h0200, "R7 noack header");
        recv_byte(mdl[12'h200], 1'b0, "R7 last byte");
        send_byte(8'hFF, 1'b0, "R7 silent after noack");
        do_stop();
        do_start();
        send_byte(8'hAB, 1'b1, "R7 resume select");
        recv_byte(mdl[12'h201], 1'b0, "R7 resume next");
        do_stop();

        tick(10);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule